// File: doc/BRIEF.md
# TDM Frame Serial Port

This block moves time-division-multiplexed frames between a pair of one-bit serial lines and two parallel word streams. A bit clock and a frame sync come from outside the block. Both are sampled on the block's own system clock, which must run at least four times faster than the bit clock. Configuration inputs set the number of elements in a frame, the element word length, the sync polarity and the data delay, which is the number of bit periods between the sync and the first data bit. Frames are always single-phase.

Each element that arrives is delivered on the receive stream as a word with a one-cycle valid strobe and its position in the frame. The receive stream has no ready input. The serial line cannot be paused, so the consumer must take every word in the cycle it appears. The transmit stream uses valid/ready. The block holds one word in a holding register. `tx_ready_o` is high only while that register is empty, and a word is taken on any cycle where valid and ready are both high. The word is kept until its element slot begins on the line. If the producer is late, the slot carries zeros and a sticky flag records it.

A frame sync that arrives before the current frame has finished restarts the frame and sets a separate sticky flag. Both sticky flags clear only on reset.

Top module: `tdm_serdes`

## Requirements
- R1: The frame-length input holds the element count minus one. A frame carries exactly `cfg_frame_len`+1 elements, with indices 0 up to `cfg_frame_len`, so a value of 31 (11111b) gives 32 elements.
- R2: The element length is 8+4×`cfg_word_code` bits, capped at DATA_W (16 by default), so codes 0, 1, 2 and 3 give 8, 12, 16 and 16 bits. A received word sits in the low bits of `rx_word_o` with zeros above it. Transmit-word bits above the element length are ignored.
- R3: `cfg_delay` gives the data delay, with 3 treated as 2. At delay 0 the first data bit occupies the bit period in which the sync is sampled active. At delays 1 and 2 it occupies the period that many periods later. `tx_data_o` is 0 in every period that carries no data bit.
- R4: Elements travel most significant bit first in both directions, and elements run in index order. Receive data is sampled at the falling edge of the bit clock. Transmit data changes at the rising edge, except that at delay 0 the first bit of a frame is driven at the falling edge where the sync is detected.
- R5: When `cfg_fs_low` is 1 the frame sync is active low. When it is 0 the sync is active high.
- R6: Each received element produces a `rx_valid_o` pulse of exactly one system-clock cycle, together with its word and `rx_index_o`. There is no back-pressure on this stream.
- R7: `tx_ready_o` is high exactly while the holding register is empty. A word is accepted when `tx_valid_i` and `tx_ready_o` are both high, and that word is sent in the next element slot to start.
- R8: If the holding register is empty when an element slot starts, that element is sent as all zeros and `err_urun_o` is set. The flag stays set until reset.
- R9: A sync start that occurs while a frame is still in progress restarts the frame at element 0 and sets `err_sync_o`. The flag stays set until reset.
- R10: Only a change of the sync from inactive to active starts a frame. A sync held active over several bit periods starts one frame and sets no error.
- R11: During and after reset, `rx_valid_o`, `tx_data_o`, `err_sync_o` and `err_urun_o` are 0 and `tx_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_frame_len | input | FL_W | Elements per frame minus one |
| cfg_word_code | input | 2 | Element length code |
| cfg_delay | input | 2 | Data delay in bit periods |
| cfg_fs_low | input | 1 | 1: frame sync active low |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External frame sync |
| rx_data_i | input | 1 | Serial receive line |
| tx_data_o | output | 1 | Serial transmit line |
| rx_valid_o | output | 1 | Received word strobe |
| rx_word_o | output | DATA_W | Received word, right aligned |
| rx_index_o | output | FL_W | Element index of the received word |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Holding register empty |
| tx_word_i | input | DATA_W | Transmit word, right aligned |
| err_sync_o | output | 1 | Sticky early-sync flag |
| err_urun_o | output | 1 | Sticky transmit underrun flag |

## Verification
The bench sweeps every combination of word code, delay code, polarity and two frame lengths, then runs a full 32-element frame. If the count-minus-one rule were handled wrongly, the frame would gain or lose an element. If the delay counter were off by one, every word would be shifted by a bit in one direction or the other, and stray ones would appear in the delay slots of the transmit line. If the sync were decoded on its level rather than on its edge, a sync held for three periods would restart the frame or raise the error flag. Separate runs starve the transmit holding register, where zeros and the flag are expected, and cut a frame short with a new sync, where the bench expects a clean frame from element 0 and the sticky error.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // element length in bits for a word-length code, capped at the data width
  function automatic int unsigned word_len(input logic [1:0] code, input int unsigned dw);
    int unsigned n;
    n = 8 + 4 * int'(code);
    if (n > dw) n = dw;
    return n;
  endfunction
endpackage

// File: rtl/tdm_edge.sv
module tdm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic rx_i,
  input  logic fs_low,
  output logic fall,
  output logic rise,
  output logic fs_act,
  output logic rx_bit
);
  logic b1, b2, f1, r1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b1 <= 1'b0;
      b2 <= 1'b0;
      f1 <= 1'b0;
      r1 <= 1'b0;
    end else begin
      b1 <= bclk_i;
      b2 <= b1;
      f1 <= fs_i;
      r1 <= rx_i;
    end
  end

  assign fall   = b2 & ~b1;
  assign rise   = ~b2 & b1;
  assign fs_act = f1 ^ fs_low;
  assign rx_bit = r1;
endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl #(
  parameter int FL_W  = 5,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             fs_act,
  input  logic [FL_W-1:0]  cfg_frame_len,
  input  logic [BIT_W-1:0] wmax,
  input  logic [1:0]       delay,
  output logic             data_now,
  output logic             last_bit,
  output logic [FL_W-1:0]  cur_elem,
  output logic             start_now,
  output logic             next_data,
  output logic             next_first,
  output logic             err_o
);
  logic             act_q, act_n, fs_prev, sync;
  logic [1:0]       dly_q, dly_n, dmax;
  logic [BIT_W-1:0] bit_q, bit_n, cur_bit;
  logic [FL_W-1:0]  elem_q, elem_n;

  always_comb begin
    dmax     = (delay == 2'd3) ? 2'd2 : delay;
    sync     = fall & fs_act & ~fs_prev;
    cur_bit  = sync ? wmax : bit_q;
    cur_elem = sync ? '0 : elem_q;
    data_now = sync ? (dmax == 2'd0) : (fall & act_q & (dly_q <= 2'd1));
    last_bit = data_now & (cur_bit == '0);
    act_n  = act_q;
    dly_n  = dly_q;
    bit_n  = bit_q;
    elem_n = elem_q;
    if (sync) begin
      act_n  = 1'b1;
      dly_n  = dmax;
      bit_n  = wmax;
      elem_n = '0;
    end else if (fall && act_q && dly_q != 2'd0) begin
      dly_n = dly_q - 2'd1;
    end
    if (data_now) begin
      if (cur_bit == '0) begin
        bit_n = wmax;
        if (cur_elem == cfg_frame_len) act_n = 1'b0;
        else elem_n = cur_elem + 1'b1;
      end else begin
        bit_n = cur_bit - 1'b1;
      end
    end
    next_data  = act_n & (dly_n <= 2'd1);
    next_first = (bit_n == wmax);
    start_now  = sync & (dmax == 2'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      fs_prev <= 1'b0;
      dly_q   <= '0;
      bit_q   <= '0;
      elem_q  <= '0;
      err_o   <= 1'b0;
    end else if (fall) begin
      act_q   <= act_n;
      fs_prev <= fs_act;
      dly_q   <= dly_n;
      bit_q   <= bit_n;
      elem_q  <= elem_n;
      if (sync && act_q) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
  parameter int DATA_W = 16,
  parameter int FL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_now,
  input  logic              last_bit,
  input  logic [FL_W-1:0]   cur_elem,
  input  logic              rx_bit,
  input  logic [DATA_W-1:0] mask,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic [FL_W-1:0]   rx_index_o
);
  logic [DATA_W-1:0] sh, sh_n;

  assign sh_n = {sh[DATA_W-2:0], rx_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh         <= '0;
      rx_valid_o <= 1'b0;
      rx_word_o  <= '0;
      rx_index_o <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (data_now) begin
        sh <= sh_n;
        if (last_bit) begin
          rx_valid_o <= 1'b1;
          rx_word_o  <= sh_n & mask;
          rx_index_o <= cur_elem;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
  parameter int DATA_W = 16,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              rise,
  input  logic              start_now,
  input  logic              next_data,
  input  logic              next_first,
  input  logic [BIT_W:0]    align,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              tx_ready_o,
  output logic              tx_data_o,
  output logic              urun_o
);
  logic              full, pend, accept, consume;
  logic [DATA_W-1:0] hold, sh, aligned;

  assign tx_ready_o = ~full;
  assign accept     = tx_valid_i & ~full;
  assign consume    = fall & (start_now | (next_data & next_first));
  assign aligned    = (full ? hold : '0) << align;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold      <= '0;
      sh        <= '0;
      pend      <= 1'b0;
      tx_data_o <= 1'b0;
      urun_o    <= 1'b0;
    end else begin
      if (accept) hold <= tx_word_i;
      if (consume) full <= accept;
      else if (accept) full <= 1'b1;
      if (consume && !full) urun_o <= 1'b1;
      if (fall) begin
        if (start_now) begin
          tx_data_o <= aligned[DATA_W-1];
          sh        <= aligned << 1;
          pend      <= next_data;
        end else if (consume) begin
          sh   <= aligned;
          pend <= 1'b1;
        end else begin
          pend <= next_data;
        end
      end else if (rise) begin
        tx_data_o <= pend & sh[DATA_W-1];
        if (pend) sh <= sh << 1;
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_serdes.sv
module tdm_serdes #(
  parameter int DATA_W = 16,
  parameter int FL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FL_W-1:0]   cfg_frame_len,
  input  logic [1:0]        cfg_word_code,
  input  logic [1:0]        cfg_delay,
  input  logic              cfg_fs_low,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              rx_data_i,
  output logic              tx_data_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic [FL_W-1:0]   rx_index_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              err_sync_o,
  output logic              err_urun_o
);
  import tdm_pkg::*;
  localparam int BIT_W = $clog2(DATA_W);

  logic              fall, rise, fs_act, rx_bit;
  logic [BIT_W:0]    wl, align;
  logic [BIT_W-1:0]  wmax;
  logic [DATA_W-1:0] mask;
  logic              data_now, last_bit, start_now, next_data, next_first;
  logic [FL_W-1:0]   cur_elem;

  always_comb begin
    wl    = (BIT_W+1)'(word_len(cfg_word_code, DATA_W));
    wmax  = BIT_W'(wl - 1'b1);
    align = (BIT_W+1)'(DATA_W) - wl;
    mask  = {DATA_W{1'b1}} >> align;
  end

  tdm_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fs_i(fsync_i), .rx_i(rx_data_i),
    .fs_low(cfg_fs_low), .fall(fall), .rise(rise), .fs_act(fs_act), .rx_bit(rx_bit)
  );

  tdm_frame_ctrl #(.FL_W(FL_W), .BIT_W(BIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall(fall), .fs_act(fs_act),
    .cfg_frame_len(cfg_frame_len), .wmax(wmax), .delay(cfg_delay),
    .data_now(data_now), .last_bit(last_bit), .cur_elem(cur_elem),
    .start_now(start_now), .next_data(next_data), .next_first(next_first),
    .err_o(err_sync_o)
  );

  tdm_rx_path #(.DATA_W(DATA_W), .FL_W(FL_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .data_now(data_now), .last_bit(last_bit),
    .cur_elem(cur_elem), .rx_bit(rx_bit), .mask(mask),
    .rx_valid_o(rx_valid_o), .rx_word_o(rx_word_o), .rx_index_o(rx_index_o)
  );

  tdm_tx_path #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise), .start_now(start_now),
    .next_data(next_data), .next_first(next_first), .align(align),
    .tx_valid_i(tx_valid_i), .tx_word_i(tx_word_i), .tx_ready_o(tx_ready_o),
    .tx_data_o(tx_data_o), .urun_o(err_urun_o)
  );
endmodule

// File: rtl/tdm_serdes_chk.sv
module tdm_serdes_chk #(
  parameter int FL_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_valid_o,
  input logic [FL_W-1:0] rx_index_o,
  input logic [FL_W-1:0] cfg_frame_len,
  input logic            tx_valid_i,
  input logic            tx_ready_o,
  input logic            err_sync_o,
  input logic            err_urun_o
);
  // R6: a received word is strobed for a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R1: element index never passes the configured last element
  a_r1_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> rx_index_o <= cfg_frame_len);

  // R7: an accepted word fills the holding register
  a_r7_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R8: underrun flag is sticky
  a_r8_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_urun_o |=> err_urun_o);

  // R9: early-sync flag is sticky
  a_r9_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_sync_o |=> err_sync_o);
endmodule

bind tdm_serdes tdm_serdes_chk #(.FL_W(FL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid_o(rx_valid_o), .rx_index_o(rx_index_o),
  .cfg_frame_len(cfg_frame_len), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
  .err_sync_o(err_sync_o), .err_urun_o(err_urun_o)
);

// File: tb/sim_tdm_serdes.sv
module sim_tdm_serdes;
  localparam int DW = 16;
  localparam int FW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [FW-1:0] cfg_frame_len = '0;
  logic [1:0]    cfg_word_code = '0;
  logic [1:0]    cfg_delay = '0;
  logic          cfg_fs_low = 1'b0;
  logic          bclk_i = 1'b0, fsync_i = 1'b0, rx_data_i = 1'b0;
  logic          tx_data_o, rx_valid_o, tx_ready_o, err_sync_o, err_urun_o;
  logic [DW-1:0] rx_word_o, tx_word_i;
  logic [FW-1:0] rx_index_o;
  logic          tx_valid_i;

  tdm_serdes #(.DATA_W(DW), .FL_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_frame_len(cfg_frame_len), .cfg_word_code(cfg_word_code),
    .cfg_delay(cfg_delay), .cfg_fs_low(cfg_fs_low), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .rx_data_i(rx_data_i), .tx_data_o(tx_data_o), .rx_valid_o(rx_valid_o),
    .rx_word_o(rx_word_o), .rx_index_o(rx_index_o), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .tx_word_i(tx_word_i), .err_sync_o(err_sync_o),
    .err_urun_o(err_urun_o)
  );

  int errors = 0;
  int checks = 0;
  int feed_idx = 0, feed_lim = 0, seed = 0, cur_wl = 8;
  bit feed_en = 1'b0, acc = 1'b0;
  logic [DW-1:0] got_w [32];
  int got_n = 0;
  bit order_bad = 1'b0;

  function automatic logic [DW-1:0] mk(input int k, input int s, input int wl, input int salt);
    int unsigned v;
    v = (k + 1) * 40503 ^ (s * 7919) ^ salt;
    v = v ^ (v >> 7);
    return DW'(v & ((32'd1 << wl) - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // transmit producer: sequence changes only at negative edges
  always @(negedge clk) begin
    if (acc) feed_idx = feed_idx + 1;
    tx_valid_i = feed_en && (feed_idx < feed_lim);
    tx_word_i  = mk(feed_idx, seed, cur_wl, 'h5a5) | DW'(~((32'd1 << cur_wl) - 1));
    acc        = tx_valid_i && tx_ready_o;
  end

  // receive monitor
  always @(negedge clk) begin
    if (rx_valid_o) begin
      if (rx_index_o != FW'(got_n)) order_bad = 1'b1;
      if (got_n < 32) got_w[got_n] = rx_word_o;
      got_n = got_n + 1;
    end
  end

  task automatic bit_period(input bit fsv, input bit rxv, output bit txs);
    bclk_i    = 1'b1;
    fsync_i   = fsv ^ cfg_fs_low;
    rx_data_i = rxv;
    repeat (4) @(negedge clk);
    bclk_i = 1'b0;
    repeat (4) @(negedge clk);
    txs = tx_data_o;
  endtask

  task automatic run_frame(input int fl, input int wc, input int dl, input int pol,
                           input int nfeed, input int fs_len, input int lead,
                           input int cut, input bit do_chk);
    int wl, de, n, total, zbad;
    bit t;
    logic [DW-1:0] txacc [32];
    logic [DW-1:0] w, e;
    wl = (wc == 3) ? 16 : 8 + 4 * wc;
    de = (dl == 3) ? 2 : dl;
    n  = (fl + 1) * wl;
    zbad = 0;
    for (int i = 0; i < 32; i++) txacc[i] = '0;
    @(posedge clk);
    cfg_frame_len = FW'(fl);
    cfg_word_code = 2'(wc);
    cfg_delay     = 2'(dl);
    cfg_fs_low    = pol[0];
    seed      = seed + 1;
    cur_wl    = wl;
    feed_idx  = 0;
    feed_lim  = nfeed;
    feed_en   = 1'b1;
    acc       = 1'b0;
    got_n     = 0;
    order_bad = 1'b0;
    @(negedge clk);
    for (int i = 0; i < lead; i++) begin
      bit_period(1'b0, 1'b0, t);
      if (t) zbad++;
    end
    total = (cut > 0) ? cut : de + n + 2;
    for (int p = 0; p < total; p++) begin
      int d;
      d = p - de;
      if (d >= 0 && d < n) begin
        int k, b;
        k = d / wl;
        b = wl - 1 - (d % wl);
        w = mk(k, seed, wl, 'h33);
        bit_period(p < fs_len, w[b], t);
        txacc[k][b] = t;
      end else begin
        bit_period(p < fs_len, 1'b0, t);
        if (t) zbad++;
      end
    end
    if (do_chk) begin
      chk(got_n == fl + 1, "R1", "received element count", got_n, fl + 1);
      chk(!order_bad, "R6", "index order of rx strobes", order_bad, 0);
      for (int k = 0; k <= fl && k < 32; k++) begin
        e = mk(k, seed, wl, 'h33);
        chk(got_w[k] == e, "R4,R2,R5", "rx word", got_w[k], e);
        e = (k < nfeed) ? mk(k, seed, wl, 'h5a5) : '0;
        chk(txacc[k] == e, (k < nfeed) ? "R4,R7,R2" : "R8", "tx element", txacc[k], e);
      end
      chk(zbad == 0, "R3", "tx ones outside data bits", zbad, 0);
    end
    feed_en = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    chk(rx_valid_o == 1'b0, "R11", {tag, " rx_valid"}, rx_valid_o, 0);
    chk(tx_data_o == 1'b0, "R11", {tag, " tx_data"}, tx_data_o, 0);
    chk(tx_ready_o == 1'b1, "R11,R7", {tag, " tx_ready"}, tx_ready_o, 1);
    chk(err_sync_o == 1'b0, "R11", {tag, " err_sync"}, err_sync_o, 0);
    chk(err_urun_o == 1'b0, "R11", {tag, " err_urun"}, err_urun_o, 0);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        check_idle("in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("after reset");
        // sweep: frame length, word code, delay, polarity
        for (int fl = 0; fl <= 2; fl += 2)
          for (int wc = 0; wc < 4; wc++)
            for (int dl = 0; dl < 4; dl++)
              for (int pol = 0; pol < 2; pol++)
                run_frame(fl, wc, dl, pol, fl + 1, 1, 2, 0, 1);
        // R1: field 11111b gives 32 elements
        run_frame(31, 0, 1, 1, 32, 1, 2, 0, 1);
        chk(err_sync_o == 1'b0, "R9", "no early sync in clean frames", err_sync_o, 0);
        chk(err_urun_o == 1'b0, "R8", "no underrun when fed", err_urun_o, 0);
        // R10: sync held active for three periods
        run_frame(2, 1, 0, 0, 3, 3, 2, 0, 1);
        chk(err_sync_o == 1'b0, "R10", "long sync is one start", err_sync_o, 0);
        // R8: only two words for four elements
        run_frame(3, 0, 0, 0, 2, 1, 2, 0, 1);
        chk(err_urun_o == 1'b1, "R8", "underrun flag", err_urun_o, 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("second reset");
        // R9: sync in bit period 12 of a 32-bit frame
        run_frame(3, 0, 0, 0, 2, 1, 2, 12, 0);
        run_frame(3, 0, 0, 0, 4, 1, 0, 0, 1);
        chk(err_sync_o == 1'b1, "R9", "early sync flag", err_sync_o, 1);
        chk(err_urun_o == 1'b0, "R8", "no underrun on restart", err_urun_o, 0);
      end
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule